// File: doc/BRIEF.md
# Polled Command Word Frequency Hop Controller

This block turns a 32-bit command word, which software keeps in a shared dual-port memory, into tuning-word updates for a frequency synthesizer. Software writes the word through its own port of the memory. This block reads the word through the opposite port at a fixed polling period and compares each new sample with the previous one, bit by bit.

Three edges on the low bits of the word act as commands. A falling edge on bit 0 or on bit 2 re-initialises the synthesizer to the starting frequency. A rising edge on bit 1 starts a timed hop sequence that wraps through four table entries.

Every change of frequency appears as a 32-bit tuning word with a one-cycle load strobe, meant for a downstream serializer. That serializer can hold off new strobes with its busy input. The four tuning words are parameters. Their defaults correspond to 100, 140, 200 and 330 MHz from a 1 GHz reference.

Top module: `hop_cmd_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `mem_en`, `tw_load` and `hop_active` are 0 and `tw_out` is 0.
- R2: `mem_en` pulses high for one cycle once every `POLL_CYCLES` cycles, always with `mem_addr` equal to `CMD_ADDR`. The read data is taken `RD_LAT` cycles after the pulse.
- R3: The first sample after reset only records the word and never acts as a command, whatever its value.
- R4: A 1-to-0 change of bit 0 between consecutive samples is an initialise command. It clears `hop_active` and issues one strobe carrying `TW0`.
- R5: A 1-to-0 change of bit 2 is the same initialise command as R4.
- R6: A 0-to-1 change of bit 1 starts hopping. It sets `hop_active` and issues a strobe with `TW0` right away. The same edge during hopping restarts the sequence at `TW0`.
- R7: While hopping, the strobes carry `TW0`, `TW1`, `TW2`, `TW3` and then `TW0` again, endlessly. Consecutive strobes are exactly `DWELL_CYCLES` cycles apart when `sync_busy` is low.
- R8: An initialise command during hopping stops the sequence at once and returns the index to the first entry. The only strobe that follows carries `TW0`, and no hop strobes follow it.
- R9: When one sample holds both an initialise edge and a start edge, initialise wins. `hop_active` stays 0 and the strobe carries `TW0`.
- R10: `tw_load` is never high on two consecutive cycles, and `tw_out` holds its value between strobes. No strobe is issued in a cycle after `sync_busy` was sampled high. A deferred update is issued on the cycle after `sync_busy` falls.
- R11: The following changes produce no strobe and no change of `hop_active`: a rising edge on bit 0 or bit 2, a falling edge on bit 1, and any change of bits 31:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_en | output | 1 | Read enable towards the memory port |
| mem_addr | output | ADDR_W | Read address, fixed at CMD_ADDR |
| mem_rdata | input | 32 | Read data, valid RD_LAT cycles after mem_en |
| sync_busy | input | 1 | Downstream serializer busy; holds off strobes |
| tw_out | output | TW_W | Current tuning word |
| tw_load | output | 1 | One-cycle strobe: tw_out holds a new word |
| hop_active | output | 1 | High while the hop sequence runs |

## Verification
Some properties are checked on every cycle. The read port is only ever enabled at the command address and only for a single cycle. The strobe is one cycle wide and never follows a busy cycle. A strobe outside of hopping always carries the first table entry. A start of hopping is followed by a strobe of the first entry.

Other behaviour shows only across the bench's command sequences:
- the edge decoding and the priming of the first sample;
- the order and spacing of the hop steps, and their wrap;
- the deferral of strobes while busy;
- the rule that ignored transitions leave both outputs untouched.

Random command words then compare `hop_active` and the strobes against a model of edge priority.

// File: rtl/hop_cmd_ctrl.sv
module hop_cmd_ctrl #(
  parameter int                ADDR_W       = 10,
  parameter logic [ADDR_W-1:0] CMD_ADDR     = '0,
  parameter int                POLL_CYCLES  = 64,
  parameter int                RD_LAT       = 1,
  parameter int                DWELL_CYCLES = 125000,
  parameter int                TW_W         = 32,
  parameter logic [TW_W-1:0]   TW0          = 32'h1999_999A,
  parameter logic [TW_W-1:0]   TW1          = 32'h23D7_0A3D,
  parameter logic [TW_W-1:0]   TW2          = 32'h3333_3333,
  parameter logic [TW_W-1:0]   TW3          = 32'h547A_E148
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [31:0]       mem_rdata,
  input  logic              sync_busy,
  output logic [TW_W-1:0]   tw_out,
  output logic              tw_load,
  output logic              hop_active
);

  localparam int PW = (POLL_CYCLES  > 1) ? $clog2(POLL_CYCLES)  : 1;
  localparam int DW = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1;
  localparam logic [PW-1:0] POLL_LAST  = PW'(POLL_CYCLES - 1);
  localparam logic [DW-1:0] DWELL_LAST = DW'(DWELL_CYCLES - 1);

  logic [PW-1:0]     poll_cnt;
  logic [RD_LAT-1:0] rd_sr;
  logic [2:0]        prev;
  logic              primed;
  logic [DW-1:0]     dwell_cnt;
  logic [1:0]        idx;
  logic              pending;
  logic [TW_W-1:0]   tw_sel;

  wire       sample_vld = rd_sr[RD_LAT-1];
  wire [2:0] fall       = prev & ~mem_rdata[2:0];
  wire [2:0] rise       = ~prev & mem_rdata[2:0];
  wire       want_init  = sample_vld && primed && (fall[0] || fall[2]);
  wire       want_hop   = sample_vld && primed && rise[1];
  wire       step       = hop_active && (dwell_cnt == DWELL_LAST);
  wire       load_go    = pending && !sync_busy && !tw_load;

  assign mem_addr = CMD_ADDR;

  always_comb begin
    case (idx)
      2'd0:    tw_sel = TW0;
      2'd1:    tw_sel = TW1;
      2'd2:    tw_sel = TW2;
      default: tw_sel = TW3;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_cnt <= '0;
      mem_en   <= 1'b0;
      rd_sr    <= '0;
    end else begin
      poll_cnt <= (poll_cnt == POLL_LAST) ? '0 : poll_cnt + 1'b1;
      mem_en   <= (poll_cnt == '0);
      rd_sr    <= (RD_LAT)'({rd_sr, mem_en});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev       <= '0;
      primed     <= 1'b0;
      dwell_cnt  <= '0;
      idx        <= '0;
      pending    <= 1'b0;
      hop_active <= 1'b0;
      tw_load    <= 1'b0;
      tw_out     <= '0;
    end else begin
      if (sample_vld) begin
        prev   <= mem_rdata[2:0];
        primed <= 1'b1;
      end

      tw_load <= load_go;
      if (load_go) begin
        tw_out  <= tw_sel;
        pending <= 1'b0;
      end

      if (step) begin
        idx       <= idx + 2'd1;
        dwell_cnt <= '0;
        pending   <= 1'b1;
      end else if (hop_active) begin
        dwell_cnt <= dwell_cnt + 1'b1;
      end

      if (want_init) begin
        hop_active <= 1'b0;
        idx        <= '0;
        dwell_cnt  <= '0;
        pending    <= 1'b1;
      end else if (want_hop) begin
        hop_active <= 1'b1;
        idx        <= '0;
        dwell_cnt  <= '0;
        pending    <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/hop_cmd_ctrl_chk.sv
module hop_cmd_ctrl_chk #(
  parameter int                ADDR_W   = 10,
  parameter logic [ADDR_W-1:0] CMD_ADDR = '0,
  parameter int                TW_W     = 32,
  parameter logic [TW_W-1:0]   TW0      = '0,
  parameter logic [TW_W-1:0]   TW1      = '0,
  parameter logic [TW_W-1:0]   TW2      = '0,
  parameter logic [TW_W-1:0]   TW3      = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              sync_busy,
  input logic [TW_W-1:0]   tw_out,
  input logic              tw_load,
  input logic              hop_active
);

  p_read_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> mem_addr == CMD_ADDR);

  p_read_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |=> !mem_en);

  p_strobe_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tw_load |=> !tw_load);

  p_busy_holdoff_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tw_load |-> !$past(sync_busy));

  p_table_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tw_load |-> (tw_out == TW0 || tw_out == TW1 || tw_out == TW2 || tw_out == TW3));

  p_idle_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tw_load && !hop_active && !$past(hop_active)) |-> tw_out == TW0);

  p_hop_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hop_active) && !sync_busy && !tw_load) |=> (tw_load && tw_out == TW0));

endmodule

bind hop_cmd_ctrl hop_cmd_ctrl_chk #(
  .ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR), .TW_W(TW_W),
  .TW0(TW0), .TW1(TW1), .TW2(TW2), .TW3(TW3)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .mem_addr(mem_addr),
  .sync_busy(sync_busy), .tw_out(tw_out), .tw_load(tw_load),
  .hop_active(hop_active)
);

// File: tb/tb_hop_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_hop_cmd_ctrl;
  localparam int ADDR_W = 10;
  localparam logic [ADDR_W-1:0] CMD_ADDR = 10'h040;
  localparam int POLL  = 8;
  localparam int DWELL = 40;
  localparam logic [31:0] T0 = 32'h1999_999A, T1 = 32'h23D7_0A3D,
                          T2 = 32'h3333_3333, T3 = 32'h547A_E148;
  localparam int SETTLE = 2*POLL + 4;

  logic clk = 1'b0, rst_n = 1'b0, sync_busy = 1'b0;
  logic mem_en, tw_load, hop_active;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0] mem_rdata = '0, tw_out, cmd;

  int errors = 0, checks = 0, cyc = 0, n = 0, bad_addr = 0, en_cnt = 0;
  logic [31:0] lg_val [0:1023];
  int          lg_t   [0:1023];

  always #4 clk = ~clk;

  hop_cmd_ctrl #(.ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR), .POLL_CYCLES(POLL),
    .RD_LAT(1), .DWELL_CYCLES(DWELL), .TW_W(32),
    .TW0(T0), .TW1(T1), .TW2(T2), .TW3(T3)) dut (
    .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .sync_busy(sync_busy), .tw_out(tw_out),
    .tw_load(tw_load), .hop_active(hop_active));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_en) mem_rdata <= (mem_addr == CMD_ADDR) ? cmd : 32'hDEAD_BEEF;
  end

  always @(negedge clk) if (rst_n) begin
    if (mem_en) begin
      en_cnt++;
      if (mem_addr != CMD_ADDR) bad_addr++;
    end
    if (tw_load && n < 1024) begin
      lg_val[n] = tw_out; lg_t[n] = cyc; n++;
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic put(logic [31:0] w);
    @(negedge clk); cmd = w; wait_cyc(SETTLE);
  endtask

  function automatic bit exp_active(logic [31:0] p, logic [31:0] q, bit a);
    if ((p[0] && !q[0]) || (p[2] && !q[2])) return 1'b0;
    if (!p[1] && q[1]) return 1'b1;
    return a;
  endfunction

  function automatic bit is_cmd(logic [31:0] p, logic [31:0] q);
    return (p[0] && !q[0]) || (p[2] && !q[2]) || (!p[1] && q[1]);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n0, e0;
    logic [31:0] prevw, w;
    bit act;
    void'($urandom(32'd24681));
    cmd = 32'h0000_0002;
    wait_cyc(5);
    chk(mem_en == 0 && tw_load == 0 && hop_active == 0, "R1 reset outputs",
        {29'd0, mem_en, tw_load, hop_active}, 0);
    chk(tw_out == 0, "R1 reset word", tw_out, 0);
    @(negedge clk); rst_n = 1'b1;
    wait_cyc(3*POLL);
    chk(n == 0 && hop_active == 0, "R3 first sample primes only", n, 0);

    e0 = en_cnt; wait_cyc(10*POLL);
    chk(en_cnt - e0 == 10, "R2 poll rate", en_cnt - e0, 10);

    n0 = n; put(32'h0);
    chk(n == n0 && hop_active == 0, "R11 bit1 fall ignored", n - n0, 0);
    n0 = n; put(32'h1);
    chk(n == n0, "R11 bit0 rise ignored", n - n0, 0);
    n0 = n; put(32'h0);
    chk(n == n0 + 1 && lg_val[n0] == T0 && hop_active == 0, "R4 bit0 fall init",
        lg_val[n0], T0);
    n0 = n; put(32'h4);
    chk(n == n0, "R11 bit2 rise ignored", n - n0, 0);
    n0 = n; put(32'h0);
    chk(n == n0 + 1 && lg_val[n0] == T0, "R5 bit2 fall init", lg_val[n0], T0);
    n0 = n; put(32'hFFFF_FFF8); put(32'h0);
    chk(n == n0 && hop_active == 0, "R11 upper bits ignored", n - n0, 0);

    n0 = n; put(32'h2); wait_cyc(4*DWELL + 10 - SETTLE);
    chk(hop_active == 1, "R6 hopping active", hop_active, 1);
    chk(n - n0 == 5, "R7 hop strobe count", n - n0, 5);
    chk(lg_val[n0] == T0, "R6 start word", lg_val[n0], T0);
    chk(lg_val[n0+1] == T1 && lg_val[n0+2] == T2 && lg_val[n0+3] == T3,
        "R7 hop order", lg_val[n0+3], T3);
    chk(lg_val[n0+4] == T0, "R7 wrap", lg_val[n0+4], T0);
    for (int i = 1; i < 5; i++)
      chk(lg_t[n0+i] - lg_t[n0+i-1] == DWELL, "R7 dwell spacing",
          lg_t[n0+i] - lg_t[n0+i-1], DWELL);

    put(32'h3);
    chk(hop_active == 1, "R11 bit0 rise keeps hopping", hop_active, 1);
    put(32'h2);
    chk(hop_active == 0 && lg_val[n-1] == T0, "R8 init stops hop", lg_val[n-1], T0);
    n0 = n; wait_cyc(3*DWELL);
    chk(n == n0 && hop_active == 0, "R8 no strobes after stop", n - n0, 0);

    put(32'h1);
    n0 = n; put(32'h2);
    chk(hop_active == 0 && n == n0 + 1 && lg_val[n0] == T0, "R9 init over start",
        {31'd0, hop_active}, 0);

    put(32'h1);
    @(negedge clk); sync_busy = 1'b1;
    n0 = n; put(32'h0); wait_cyc(POLL);
    chk(n == n0 && tw_load == 0, "R10 held while busy", n - n0, 0);
    sync_busy = 1'b0;
    @(negedge clk);
    chk(tw_load == 1 && tw_out == T0, "R10 deferred strobe", tw_out, T0);
    @(negedge clk);
    chk(tw_load == 0 && tw_out == T0, "R10 one cycle and hold", {31'd0, tw_load}, 0);

    prevw = cmd; act = 1'b0;
    for (int k = 0; k < 40; k++) begin
      w = $urandom;
      if (k % 5 == 0) w = prevw ^ 32'h7;
      n0 = n;
      put(w);
      act = exp_active(prevw, w, act);
      chk(hop_active == act, "R11 random hop state", hop_active, act);
      if (is_cmd(prevw, w)) begin
        bit seen = 1'b0;
        for (int j = n0; j < n; j++) if (lg_val[j] == T0) seen = 1'b1;
        chk(seen, "R6 random command strobe", n - n0, 1);
      end else if (!act)
        chk(n == n0, "R11 random no strobe", n - n0, 0);
      prevw = w;
    end

    chk(bad_addr == 0, "R2 read address", bad_addr, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule